// File: doc/BRIEF.md
# UART Transmit Path with Selectable-Depth FIFO

This block is the sending half of a UART. The processor writes bytes either into a single holding register, when FIFO mode is off, or into a transmit FIFO whose capacity is picked at run time. A frame engine pulls one byte at a time into a shift register and sends it on a serial line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Each serial bit lasts 16 pulses of an oversampling enable that comes from an external baud generator.

A frame never starts between baud pulses. Once data is waiting and the engine is idle, the byte is loaded on the next baud pulse, and the line falls at that same clock edge. A byte already waiting when a frame's last stop bit ends is loaded on the pulse that ends it, so there is no idle gap. When the FIFO is full, writes are refused until the engine takes the next byte. A clear input drops everything queued but lets the frame in progress finish. Two flags feed interrupt and DMA logic: one says the queue is empty, the other says the queue and the shift register are both empty.

The frame engine is a state machine with five states. IDLE goes to START on a baud pulse while data waits; this is the load. START goes to DATA after 16 pulses. DATA stays in DATA for each further data bit. After the last data bit it goes to PARITY if parity is on, otherwise to STOP. PARITY goes to STOP after one bit time. STOP stays in STOP for a second stop bit. At the end of the last stop bit, STOP goes to START if data waits (a back-to-back load) and to IDLE if not.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, txd is 1, level is 0, and thr_empty, tx_empty and can_accept are all 1.
- R2: A frame is one start bit at 0, then N data bits LSB first, then an optional parity bit, then stop bits at 1. N is 5 + wlen (wlen code 0..3 gives 5..8). There is one stop bit if two_stop is 0 and two if it is 1. Every bit lasts 16 baud_tick pulses.
- R3: The parity bit is sent only when par_en is 1. If par_stick is 1, the bit is the inverse of par_even. Otherwise the bit is the XOR of the N data bits when par_even is 1, and the inverse of that XOR when par_even is 0.
- R4: txd falls to start a frame only at a clock edge where baud_tick is 1. With data waiting and the engine idle, no frame starts while baud_tick stays low.
- R5: The capacity is 1 when fifo_en is 0, and 16 when fifo_en is 1 and deep_en is 0. When fifo_en and deep_en are both 1, the capacity is 64 shifted left by depth_sel (64, 128, 256 or 512). The level never exceeds the capacity.
- R6: A write made while level equals the capacity is refused. The level is unchanged and the refused byte is never sent.
- R7: can_accept is 0 while the queue is full. It returns to 1 right after the clock edge at which the engine takes the next byte, and a write is then accepted.
- R8: Bytes are sent in write order. A byte already waiting at the end of the last stop bit starts its frame on that same baud pulse, 8 pulses after the middle of the stop bit.
- R9: fifo_clr empties the queue, giving level 0 after one clock edge. A frame already in progress runs to completion unchanged.
- R10: thr_empty is 1 exactly when level is 0. tx_empty is 1 only when the queue is empty and no frame is in progress.
- R11: txd is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per serial bit |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_en | input | 1 | 1: FIFO mode, 0: single holding register |
| deep_en | input | 1 | 1: large capacity chosen by depth_sel, 0: 16 entries |
| depth_sel | input | 2 | Large capacity is 64 shifted left by this value |
| fifo_clr | input | 1 | Empties the queue, leaves the current frame running |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity when set |
| par_stick | input | 1 | Parity bit forced to the inverse of par_even |
| two_stop | input | 1 | Two stop bits when set |
| txd | output | 1 | Serial output, high when idle |
| thr_empty | output | 1 | Queue empty (transmit interrupt source) |
| tx_empty | output | 1 | Queue and shift register both empty |
| can_accept | output | 1 | Queue not full (DMA ready) |
| level | output | 10 | Number of queued bytes |

## Verification
The frame format is swept over all four word lengths, five parity settings (none, odd, even, and both stick values) and both stop counts. Each setting sends a pair of written bytes whose bit patterns differ, so a wrong bit order or length, a wrong parity rule or a missing stop bit shows up as a data or parity mismatch, and the pair itself shows whether the second frame follows with no gap. Single-byte tests with the baud pulses held off separate a start that waits for a pulse from one that starts early. Filling the queue to every capacity with one extra write separates exact capacity from off-by-one. Draining the 16-entry queue proves that a refused byte leaves no trace in the queue. A clear issued in the middle of a frame separates a clear that only drops the queue from one that also cuts the running frame.

// File: rtl/uart_txp_pkg.sv
`timescale 1ns/1ps
package uart_txp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
    } frame_cfg_t;

    // index of the last data bit: word length minus one (4..7)
    function automatic logic [2:0] last_bit_index(input logic [1:0] wlen);
        return {1'b1, wlen};
    endfunction

    function automatic logic parity_bit(input logic [7:0] data, input frame_cfg_t cfg);
        logic [7:0] masked;
        masked = data & (8'hFF >> (2'd3 - cfg.wlen));
        if (cfg.par_stick)
            return ~cfg.par_even;
        return cfg.par_even ? ^masked : ~^masked;
    endfunction

endpackage

// File: rtl/uart_txp_fifo.sv
`timescale 1ns/1ps
module uart_txp_fifo #(
    parameter int BASE_DEPTH  = 64,
    parameter int SMALL_DEPTH = 16,
    localparam int MAX_DEPTH  = BASE_DEPTH * 8,
    localparam int AW         = $clog2(MAX_DEPTH),
    localparam int LW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fifo_en,
    input  logic          deep_en,
    input  logic [1:0]    depth_sel,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          pop,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [7:0]    mem [MAX_DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] count;
    logic [LW-1:0] cap;
    logic          push;
    logic          pull;

    always_comb begin
        if (!fifo_en)
            cap = LW'(1);
        else if (!deep_en)
            cap = LW'(SMALL_DEPTH);
        else
            cap = LW'(BASE_DEPTH) << depth_sel;
    end

    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign push  = wr_en && !full && !clr;
    assign pull  = pop && !empty && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + 1'b1;
            if (pull)
                rd_ptr <= rd_ptr + 1'b1;
            count <= count + LW'(push) - LW'(pull);
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
    assign level   = count;

endmodule

// File: rtl/uart_txp_bit_timer.sv
`timescale 1ns/1ps
module uart_txp_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CW = $clog2(TICKS_PER_BIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic bit_done
);

    logic [CW-1:0] cnt_q;

    assign bit_done = tick && (cnt_q == CW'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/uart_txp_framer.sv
`timescale 1ns/1ps
module uart_txp_framer
    import uart_txp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bit_done,
    input  logic       have_data,
    input  logic [7:0] din,
    input  frame_cfg_t cfg,
    output logic       load,
    output logic       busy,
    output logic       txd
);

    tx_state_e  state_q;
    tx_state_e  state_d;
    logic [7:0] sh_q;
    logic [2:0] left_q;
    logic       stop_left_q;
    logic       par_q;
    logic       pe_q;
    logic       txd_q;
    logic       last_stop;

    assign last_stop = (state_q == ST_STOP) && bit_done && !stop_left_q;
    assign load = have_data && ((state_q == ST_IDLE && tick) || last_stop);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && have_data)
                    state_d = ST_START;
            end
            ST_START: begin
                if (bit_done)
                    state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done && left_q == 3'd0)
                    state_d = pe_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_done)
                    state_d = ST_STOP;
            end
            ST_STOP: begin
                if (last_stop)
                    state_d = have_data ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q       <= 1'b1;
            sh_q        <= '0;
            left_q      <= '0;
            stop_left_q <= 1'b0;
            par_q       <= 1'b0;
            pe_q        <= 1'b0;
        end else if (load) begin
            txd_q       <= 1'b0;
            sh_q        <= din;
            left_q      <= last_bit_index(cfg.wlen);
            stop_left_q <= cfg.two_stop;
            par_q       <= parity_bit(din, cfg);
            pe_q        <= cfg.par_en;
        end else begin
            case (state_q)
                ST_START: begin
                    if (bit_done) begin
                        txd_q <= sh_q[0];
                        sh_q  <= {1'b0, sh_q[7:1]};
                    end
                end
                ST_DATA: begin
                    if (bit_done) begin
                        if (left_q == 3'd0) begin
                            txd_q <= pe_q ? par_q : 1'b1;
                        end else begin
                            txd_q  <= sh_q[0];
                            sh_q   <= {1'b0, sh_q[7:1]};
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_done)
                        txd_q <= 1'b1;
                end
                ST_STOP: begin
                    if (bit_done) begin
                        txd_q       <= 1'b1;
                        stop_left_q <= 1'b0;
                    end
                end
                default: txd_q <= 1'b1;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign txd  = txd_q;

endmodule

// File: rtl/uart_tx_path.sv
`timescale 1ns/1ps
module uart_tx_path
    import uart_txp_pkg::*;
#(
    parameter int BASE_DEPTH    = 64,
    parameter int SMALL_DEPTH   = 16,
    parameter int TICKS_PER_BIT = 16,
    localparam int LEVEL_W      = $clog2(BASE_DEPTH * 8) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               fifo_en,
    input  logic               deep_en,
    input  logic [1:0]         depth_sel,
    input  logic               fifo_clr,
    input  logic [1:0]         wlen,
    input  logic               par_en,
    input  logic               par_even,
    input  logic               par_stick,
    input  logic               two_stop,
    output logic               txd,
    output logic               thr_empty,
    output logic               tx_empty,
    output logic               can_accept,
    output logic [LEVEL_W-1:0] level
);

    frame_cfg_t cfg;
    logic [7:0] head;
    logic       full;
    logic       empty;
    logic       load;
    logic       busy;
    logic       bit_done;

    assign cfg = '{wlen: wlen, par_en: par_en, par_even: par_even,
                   par_stick: par_stick, two_stop: two_stop};

    uart_txp_fifo #(
        .BASE_DEPTH (BASE_DEPTH),
        .SMALL_DEPTH(SMALL_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .fifo_en  (fifo_en),
        .deep_en  (deep_en),
        .depth_sel(depth_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (load),
        .rd_data  (head),
        .level    (level),
        .full     (full),
        .empty    (empty)
    );

    uart_txp_bit_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .restart (load),
        .bit_done(bit_done)
    );

    uart_txp_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .bit_done (bit_done),
        .have_data(!empty),
        .din      (head),
        .cfg      (cfg),
        .load     (load),
        .busy     (busy),
        .txd      (txd)
    );

    assign thr_empty  = empty;
    assign tx_empty   = empty && !busy;
    assign can_accept = !full;

endmodule

// File: rtl/uart_txp_checks.sv
`timescale 1ns/1ps
module uart_txp_checks #(
    parameter int BASE_DEPTH  = 64,
    parameter int SMALL_DEPTH = 16,
    localparam int LW         = $clog2(BASE_DEPTH * 8) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          baud_tick,
    input logic          wr_en,
    input logic          fifo_en,
    input logic          deep_en,
    input logic [1:0]    depth_sel,
    input logic          fifo_clr,
    input logic          txd,
    input logic          thr_empty,
    input logic          tx_empty,
    input logic          can_accept,
    input logic [LW-1:0] level
);

    logic [LW-1:0] cap_c;

    always_comb begin
        if (!fifo_en)
            cap_c = LW'(1);
        else if (!deep_en)
            cap_c = LW'(SMALL_DEPTH);
        else
            cap_c = LW'(BASE_DEPTH) << depth_sel;
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R11

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(baud_tick)); // R4

    AST_LEVEL_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap_c); // R5

    AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !can_accept) |=> level <= $past(level)); // R6

    AST_ACCEPT_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(can_accept) && !$past(fifo_clr)) |-> level < $past(level)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (level == '0) && thr_empty); // R9

    AST_TX_EMPTY_IMPLIES_THR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty); // R10

endmodule

bind uart_tx_path uart_txp_checks #(
    .BASE_DEPTH (BASE_DEPTH),
    .SMALL_DEPTH(SMALL_DEPTH)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .fifo_en   (fifo_en),
    .deep_en   (deep_en),
    .depth_sel (depth_sel),
    .fifo_clr  (fifo_clr),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty),
    .can_accept(can_accept),
    .level     (level)
);

// File: tb/tb_uart_tx_path.sv
`timescale 1ns/1ps
module tb_uart_tx_path;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_en = 1'b1;
    logic       deep_en = 1'b0;
    logic [1:0] depth_sel = '0;
    logic       fifo_clr = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd;
    logic       thr_empty;
    logic       tx_empty;
    logic       can_accept;
    logic [9:0] level;

    always #4 clk = ~clk;

    uart_tx_path dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .fifo_en(fifo_en), .deep_en(deep_en),
        .depth_sel(depth_sel), .fifo_clr(fifo_clr), .wlen(wlen),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .two_stop(two_stop), .txd(txd), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .can_accept(can_accept), .level(level)
    );

    int  n_chk = 0;
    int  n_err = 0;
    int  n_rx = 0;
    bit  tick_on = 1'b0;
    bit  tick_ph = 1'b0;
    bit  want_b2b = 1'b0;
    logic [7:0] exp_q[$];

    bit         mon_on = 1'b0;
    int         mcnt = 0;
    int         idle_ticks = 0;
    int         m_nb = 8;
    int         m_pe = 0;
    int         m_last = 9;
    logic [7:0] m_data = '0;
    logic       m_par = 1'b0;
    bit         m_stop_ok = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_frame();
        logic [7:0] mask;
        logic [7:0] e;
        logic       ep;
        mask = 8'hFF >> (8 - m_nb);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R6 R8 unexpected frame", int'(m_data), -1);
        end else begin
            e = exp_q.pop_front() & mask;
            chk(m_data == e, "R2 R8 data bits", int'(m_data), int'(e));
            if (m_pe != 0) begin
                ep = par_stick ? ~par_even : (par_even ? ^e : ~^e);
                chk(m_par == ep, "R3 parity bit", int'(m_par), int'(ep));
            end
            chk(m_stop_ok, "R2 stop bits high", int'(m_stop_ok), 1);
            n_rx++;
            want_b2b = (exp_q.size() > 0);
        end
    endtask

    // line monitor and baud pulse source, both away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_on = 1'b0;
            idle_ticks = 0;
        end else if (!mon_on) begin
            if (baud_tick)
                idle_ticks++;
            if (txd == 1'b0) begin
                chk(baud_tick == 1'b1, "R4 start only on baud pulse", int'(baud_tick), 1);
                if (want_b2b)
                    chk(idle_ticks == 8, "R8 back-to-back start", idle_ticks, 8);
                mon_on = 1'b1;
                mcnt = 0;
                m_nb = 5 + int'(wlen);
                m_pe = par_en ? 1 : 0;
                m_last = m_nb + m_pe + (two_stop ? 2 : 1);
                m_data = '0;
                m_par = 1'b0;
                m_stop_ok = 1'b1;
            end
        end else if (baud_tick) begin
            mcnt++;
            if (mcnt % 16 == 8) begin
                int k;
                k = mcnt / 16;
                if (k == 0)
                    chk(txd == 1'b0, "R2 start bit low", int'(txd), 0);
                else if (k <= m_nb)
                    m_data[k-1] = txd;
                else if (m_pe != 0 && k == m_nb + 1)
                    m_par = txd;
                else if (txd !== 1'b1)
                    m_stop_ok = 1'b0;
                if (k == m_last) begin
                    mon_on = 1'b0;
                    idle_ticks = 0;
                    finish_frame();
                end
            end
        end
        if (tick_on) begin
            tick_ph = ~tick_ph;
            baud_tick = tick_ph;
        end else begin
            baud_tick = 1'b0;
        end
    end

    task automatic put(input logic [7:0] b, input bit sent);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (sent)
            exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while ((!tx_empty || mon_on) && t < 60000);
        chk(tx_empty && txd, "R11 line high after drain", int'(txd), 1);
    endtask

    initial begin
        #1520000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int rx0;
        int cap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(level == 0, "R1 level", int'(level), 0);
        chk(thr_empty == 1'b1, "R1 thr_empty", int'(thr_empty), 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        chk(can_accept == 1'b1, "R1 can_accept", int'(can_accept), 1);

        // R4 no start without a baud pulse, R10 flags
        put(8'hA5, 1'b1);
        repeat (6) @(negedge clk);
        chk(txd == 1'b1, "R4 held until baud pulse", int'(txd), 1);
        chk(thr_empty == 1'b0, "R10 thr_empty with data", int'(thr_empty), 0);
        chk(tx_empty == 1'b0, "R10 tx_empty with data", int'(tx_empty), 0);
        tick_on = 1'b1;
        while (txd == 1'b1) @(negedge clk);
        chk(thr_empty == 1'b1, "R10 queue empty during frame", int'(thr_empty), 1);
        chk(tx_empty == 1'b0, "R10 tx_empty low during frame", int'(tx_empty), 0);
        wait_idle();

        // R2 R3 R8 format sweep
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 5; p++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [7:0] b;
                    @(negedge clk);
                    wlen = 2'(w);
                    par_en = (p != 0);
                    par_even = (p == 2 || p == 4);
                    par_stick = (p >= 3);
                    two_stop = s[0];
                    b = 8'((w * 53 + p * 17 + s * 101 + 7) & 255);
                    put(b, 1'b1);
                    put(~b, 1'b1);
                    wait_idle();
                end
            end
        end
        wlen = 2'd3; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0; two_stop = 1'b0;

        // R5 R6 R7 single holding register
        tick_on = 1'b0;
        fifo_en = 1'b0;
        rx0 = n_rx;
        put(8'h11, 1'b1);
        chk(level == 1, "R5 holding register level", int'(level), 1);
        chk(can_accept == 1'b0, "R5 holding register full", int'(can_accept), 0);
        put(8'h22, 1'b0);
        chk(level == 1, "R6 refused write level", int'(level), 1);
        tick_on = 1'b1;
        while (level != 0) @(negedge clk);
        chk(can_accept == 1'b1, "R7 accept after load", int'(can_accept), 1);
        wait_idle();
        chk(n_rx - rx0 == 1, "R6 only first byte sent", n_rx - rx0, 1);

        // R5 R6 R8 16-entry queue with drain
        tick_on = 1'b0;
        fifo_en = 1'b1;
        deep_en = 1'b0;
        rx0 = n_rx;
        for (int i = 0; i < 16; i++)
            put(8'((i * 11 + 3) & 255), 1'b1);
        put(8'hEE, 1'b0);
        chk(level == 16, "R5 R6 small capacity", int'(level), 16);
        chk(can_accept == 1'b0, "R6 small full flag", int'(can_accept), 0);
        tick_on = 1'b1;
        wait_idle();
        chk(n_rx - rx0 == 16, "R6 R8 drained count", n_rx - rx0, 16);

        // R5 R7 R9 large capacities
        for (int d = 0; d < 4; d++) begin
            tick_on = 1'b0;
            @(negedge clk);
            deep_en = 1'b1;
            depth_sel = 2'(d);
            cap = 64 << d;
            rx0 = n_rx;
            for (int i = 0; i <= cap; i++)
                put(8'((i * 7 + d) & 255), i == 0);
            chk(level == cap, "R5 R6 large capacity", int'(level), cap);
            chk(can_accept == 1'b0, "R7 full refuses", int'(can_accept), 0);
            tick_on = 1'b1;
            while (level == 10'(cap)) @(negedge clk);
            chk(level == cap - 1, "R7 one byte taken", int'(level), cap - 1);
            chk(can_accept == 1'b1, "R7 accepting again", int'(can_accept), 1);
            put(8'h5A, 1'b0);
            chk(level == cap, "R7 write accepted after load", int'(level), cap);
            @(negedge clk);
            fifo_clr = 1'b1;
            @(negedge clk);
            fifo_clr = 1'b0;
            chk(level == 0, "R9 cleared level", int'(level), 0);
            chk(thr_empty == 1'b1 && tx_empty == 1'b0, "R9 R10 frame continues",
                int'(tx_empty), 0);
            wait_idle();
            chk(n_rx - rx0 == 1, "R9 in-flight frame completed", n_rx - rx0, 1);
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule